// File: doc/BRIEF.md
# Clocked Serial Transmit Engine

This block sends a serial bit stream on a data line and drives a matching bit clock beside it. Software loads a 32-bit FIFO one byte at a time, sets a frame length in bits and pulses a start strobe. The engine then shifts the FIFO out one bit per period of the bit clock, most significant bit of each byte first. A non-zero length runs a fixed one-shot frame. A length of zero runs an open-ended stream, and software keeps the FIFO topped up while the stream runs.

The bit clock is derived from a source tick. The source tick is either the system clock itself or an external tick input. That tick passes through two cascaded divide-by-1-to-16 stages. Each half period of the bit clock lasts one full divided period. The engine reports the FIFO fill level at all times. It sets a done flag when a one-shot frame ends. It keeps sticky overrun and underrun flags, and each flag is cleared by its own pulse.

Top module: `sertx_engine`

## Requirements
- R1: `fill_level` always gives the number of bits held in the FIFO, from 0 to 32. An accepted byte push adds 8, and each transmitted bit removes 1.
- R2: Bytes leave in the order they were pushed, and each byte is sent most significant bit first.
- R3: A `go` pulse while idle starts a one-shot frame only if `frame_len` is between 1 and 32 and `fill_level` >= `frame_len`. Any other non-zero length is ignored: `busy` stays 0 and the FIFO is left unchanged.
- R4: While `busy`, each bit drives `txclk` low for N clock cycles and then high for N cycles. `txd` changes only as `txclk` falls, and the first bit appears on the clock edge that accepts `go`.
- R5: While idle, both `txclk` and `txd` rest at 1. This includes the state right after reset.
- R6: A one-shot frame sends exactly `frame_len` bits and then returns to idle with `done` = 1. `done` stays set until the next accepted `go`.
- R7: With `frame_len` = 0 the engine streams until a bit is due and the FIFO is empty. It then sets `und_flag`, goes idle and leaves `done` at 0. A streaming `go` given while the FIFO is empty sets `und_flag` and does not start.
- R8: A byte push that finds fewer than 8 free bits is dropped and sets `ovr_flag`. Free space is counted after any pop in the same cycle.
- R9: Both error flags are sticky. `clr_ovr` clears `ovr_flag` and `clr_und` clears `und_flag`. If a flag's event and its clear pulse arrive in the same cycle, the flag stays set.
- R10: When `clk_src_sel` = 1, the divider advances only on cycles where `aux_tick` = 1. When `clk_src_sel` = 0, it advances on every cycle.
- R11: N = (`div_lo`+1)*(`div_hi`+1) source ticks, so each field value v gives a stage ratio of v+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_src_sel | input | 1 | 0: divide the system clock, 1: divide `aux_tick` |
| aux_tick | input | 1 | Alternate source tick |
| div_lo | input | 4 | First divider stage, ratio = value+1 |
| div_hi | input | 4 | Second divider stage, ratio = value+1 |
| push_valid | input | 1 | Push `push_byte` into the FIFO |
| push_byte | input | 8 | Byte to enqueue |
| frame_len | input | 8 | Frame length in bits, 0 = streaming |
| go | input | 1 | Start strobe |
| clr_ovr | input | 1 | Clear pulse for `ovr_flag` |
| clr_und | input | 1 | Clear pulse for `und_flag` |
| fill_level | output | 6 | Bits currently held in the FIFO |
| busy | output | 1 | A frame or stream is in progress |
| done | output | 1 | Last one-shot frame completed |
| ovr_flag | output | 1 | Sticky overrun flag |
| und_flag | output | 1 | Sticky underrun flag |
| txd | output | 1 | Serial data |
| txclk | output | 1 | Bit clock |

## Verification
The bench sweeps 16 divider pairs and measures every low and high phase against N. If the two stages were summed or off by one, some phase length would be wrong. A frame of 32 bits from a full FIFO and a go with length 33 probe the boundary of one-shot mode. A design that accepted 33 would go busy, and a design that rejected 32 would never send the frame. Overrun is forced at exactly 32 held bits, with a clear pulse arriving in the same cycle. A design where the clear wins would drop the flag. Streaming runs with live refills until it starves, so a design that set `done` on underrun, or that lost bits across a refill, is exposed. A divided external tick checks that the divider waits for `aux_tick`.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    localparam int BYTE_BITS = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } tx_state_e;
endpackage

// File: rtl/sertx_clkdiv.sv
module sertx_clkdiv #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             src_i,
    input  logic [DIV_W-1:0] div_a_i,
    input  logic [DIV_W-1:0] div_b_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] a;
        logic [DIV_W-1:0] b;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d  = div_q;
        tick_o = 1'b0;
        if (!run_i) begin
            div_d = '0;
        end else if (src_i) begin
            if (div_q.a == div_a_i) begin
                div_d.a = '0;
                if (div_q.b == div_b_i) begin
                    div_d.b = '0;
                    tick_o  = 1'b1;
                end else begin
                    div_d.b = div_q.b + DIV_W'(1);
                end
            end else begin
                div_d.a = div_q.a + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // R11: with a first-stage ratio above 1, two ticks can never be adjacent
    p_tick_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_a_i != '0 && $stable(div_a_i)) |-> !$past(tick_o));

    // R10: nothing advances without a source tick
    p_src_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !src_i) |=> $stable(div_q));
endmodule

// File: rtl/sertx_bitfifo.sv
module sertx_bitfifo #(
    parameter int DEPTH  = 32,
    parameter int FILL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [7:0]        data_i,
    input  logic              pop_i,
    output logic              head_o,
    output logic [FILL_W-1:0] fill_o,
    output logic              ovf_o
);
    import sertx_pkg::*;

    typedef struct packed {
        logic [DEPTH-1:0]  bits;
        logic [FILL_W-1:0] cnt;
    } fifo_t;

    fifo_t f_d, f_q;
    int    ins_top;

    always_comb begin
        f_d     = f_q;
        ovf_o   = 1'b0;
        ins_top = 0;
        if (pop_i && f_q.cnt != '0) begin
            f_d.bits = f_q.bits << 1;
            f_d.cnt  = f_q.cnt - FILL_W'(1);
        end
        if (push_i) begin
            if (int'(f_d.cnt) <= DEPTH - BYTE_BITS) begin
                ins_top = DEPTH - 1 - int'(f_d.cnt);
                f_d.bits[ins_top -: BYTE_BITS] = data_i;
                f_d.cnt = f_d.cnt + FILL_W'(BYTE_BITS);
            end else begin
                ovf_o = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign head_o = f_q.bits[DEPTH-1];
    assign fill_o = f_q.cnt;

    p_fill_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(f_q.cnt) <= DEPTH);

    p_push_adds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && int'(f_q.cnt) <= DEPTH - BYTE_BITS)
        |=> int'(f_q.cnt) == int'($past(f_q.cnt)) + BYTE_BITS);
endmodule

// File: rtl/sertx_engine.sv
module sertx_engine #(
    parameter int FIFO_BITS = 32,
    parameter int LEN_W     = 8,
    parameter int DIV_W     = 4,
    localparam int FILL_W   = $clog2(FIFO_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_src_sel,
    input  logic              aux_tick,
    input  logic [DIV_W-1:0]  div_lo,
    input  logic [DIV_W-1:0]  div_hi,
    input  logic              push_valid,
    input  logic [7:0]        push_byte,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic              go,
    input  logic              clr_ovr,
    input  logic              clr_und,
    output logic [FILL_W-1:0] fill_level,
    output logic              busy,
    output logic              done,
    output logic              ovr_flag,
    output logic              und_flag,
    output logic              txd,
    output logic              txclk
);
    import sertx_pkg::*;

    typedef struct packed {
        tx_state_e        state;
        logic             txd;
        logic             txclk;
        logic [LEN_W-1:0] sent;
        logic [LEN_W-1:0] len;
        logic             cont;
        logic             done;
        logic             ovr;
        logic             und;
    } eng_t;

    eng_t e_d, e_q;
    logic tick, pop, head, ovf, und_evt, src;

    assign src = clk_src_sel ? aux_tick : 1'b1;

    sertx_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (e_q.state != ST_IDLE),
        .src_i  (src),
        .div_a_i(div_lo),
        .div_b_i(div_hi),
        .tick_o (tick)
    );

    sertx_bitfifo #(.DEPTH(FIFO_BITS), .FILL_W(FILL_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push_i(push_valid),
        .data_i(push_byte),
        .pop_i (pop),
        .head_o(head),
        .fill_o(fill_level),
        .ovf_o (ovf)
    );

    always_comb begin
        e_d     = e_q;
        pop     = 1'b0;
        und_evt = 1'b0;
        unique case (e_q.state)
            ST_IDLE: begin
                if (go) begin
                    if (frame_len == '0 && fill_level == '0) begin
                        und_evt = 1'b1;
                    end else if (frame_len == '0 ||
                                 (int'(frame_len) <= FIFO_BITS &&
                                  int'(fill_level) >= int'(frame_len))) begin
                        pop       = 1'b1;
                        e_d.txd   = head;
                        e_d.txclk = 1'b0;
                        e_d.state = ST_LOW;
                        e_d.sent  = LEN_W'(1);
                        e_d.len   = frame_len;
                        e_d.cont  = (frame_len == '0);
                        e_d.done  = 1'b0;
                    end
                end
            end
            ST_LOW: begin
                if (tick) begin
                    e_d.txclk = 1'b1;
                    e_d.state = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    if (!e_q.cont && e_q.sent == e_q.len) begin
                        e_d.state = ST_IDLE;
                        e_d.done  = 1'b1;
                        e_d.txd   = 1'b1;
                    end else if (fill_level == '0) begin
                        und_evt   = 1'b1;
                        e_d.state = ST_IDLE;
                        e_d.txd   = 1'b1;
                    end else begin
                        pop       = 1'b1;
                        e_d.txd   = head;
                        e_d.txclk = 1'b0;
                        e_d.sent  = e_q.sent + LEN_W'(1);
                        e_d.state = ST_LOW;
                    end
                end
            end
            default: e_d.state = ST_IDLE;
        endcase
        if (clr_ovr) e_d.ovr = 1'b0;
        if (ovf)     e_d.ovr = 1'b1;
        if (clr_und) e_d.und = 1'b0;
        if (und_evt) e_d.und = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q.state <= ST_IDLE;
            e_q.txd   <= 1'b1;
            e_q.txclk <= 1'b1;
            e_q.sent  <= '0;
            e_q.len   <= '0;
            e_q.cont  <= 1'b0;
            e_q.done  <= 1'b0;
            e_q.ovr   <= 1'b0;
            e_q.und   <= 1'b0;
        end else begin
            e_q <= e_d;
        end
    end

    assign busy     = (e_q.state != ST_IDLE);
    assign done     = e_q.done;
    assign ovr_flag = e_q.ovr;
    assign und_flag = e_q.und;
    assign txd      = e_q.txd;
    assign txclk    = e_q.txclk;

    p_idle_lines_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (txclk && txd));

    p_data_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$stable(txd)) |-> $fell(txclk));

    p_done_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(busy) && !busy));

    p_overrun_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !pop && int'(fill_level) > FIFO_BITS - 8) |=> ovr_flag);

    p_sticky_und_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (und_flag && !clr_und) |=> und_flag);
endmodule

// File: tb/sertx_engine_tb_top.sv
`timescale 1ns/1ps
module sertx_engine_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_src_sel = 1'b0;
    logic       aux_tick = 1'b0;
    logic [3:0] div_lo = '0;
    logic [3:0] div_hi = '0;
    logic       push_valid = 1'b0;
    logic [7:0] push_byte = '0;
    logic [7:0] frame_len = '0;
    logic       go = 1'b0;
    logic       clr_ovr = 1'b0;
    logic       clr_und = 1'b0;
    logic [5:0] fill_level;
    logic       busy, done, ovr_flag, und_flag, txd, txclk;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [63:0] mq = '0;
    int mc = 0;
    int aux_cnt = 0;
    bit aux_en = 1'b0;

    always #2.5 clk = ~clk;

    sertx_engine dut_i (
        .clk(clk), .rst_n(rst_n), .clk_src_sel(clk_src_sel), .aux_tick(aux_tick),
        .div_lo(div_lo), .div_hi(div_hi), .push_valid(push_valid), .push_byte(push_byte),
        .frame_len(frame_len), .go(go), .clr_ovr(clr_ovr), .clr_und(clr_und),
        .fill_level(fill_level), .busy(busy), .done(done), .ovr_flag(ovr_flag),
        .und_flag(und_flag), .txd(txd), .txclk(txclk)
    );

    // external source tick: one cycle in three
    always @(negedge clk) begin
        aux_cnt  <= (aux_cnt == 2) ? 0 : aux_cnt + 1;
        aux_tick <= aux_en && (aux_cnt == 2);
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void model_push(input logic [7:0] b);
        if (mc <= 24) begin
            mq[(63 - mc) -: 8] = b;
            mc += 8;
        end
    endfunction

    task automatic push_b(input logic [7:0] b);
        @(negedge clk);
        push_valid = 1'b1;
        push_byte  = b;
        @(negedge clk);
        push_valid = 1'b0;
        model_push(b);
    endtask

    task automatic pulse_go(input int len);
        @(negedge clk);
        frame_len = 8'(len);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
    endtask

    // Runs one frame, measuring phase lengths and comparing bits with the model
    task automatic frame(input int len, input int n, input bit skip_first, input int refill,
                         input int seed, output int nbits, output int bad_t, output int bad_b);
        logic lvl, lowbit, cur, expb;
        int run, rf, k, t;
        bit first;
        pulse_go(len);
        nbits = 0; bad_t = 0; bad_b = 0;
        lvl = txclk; run = 0; first = 1'b1; lowbit = txd; rf = refill; k = 0; t = 0;
        while (t < 40000) begin
            cur = txclk;
            if (!busy) begin
                if (lvl != 1'b1 || run != n) bad_t++;
                break;
            end
            if (cur != lvl) begin
                if (!(first && skip_first) && run != n) bad_t++;
                if (lvl == 1'b0) begin
                    if (mc > 0) begin
                        expb = mq[63];
                        mq = mq << 1;
                        mc--;
                        if (lowbit != expb) bad_b++;
                    end else begin
                        bad_b++;
                    end
                    nbits++;
                end
                first = 1'b0;
                lvl = cur;
                run = 0;
            end
            run++;
            if (cur == 1'b0) lowbit = txd;
            if (push_valid) begin
                push_valid = 1'b0;
            end else if (rf > 0 && fill_level <= 6'd16) begin
                push_valid = 1'b1;
                push_byte  = 8'((seed * 29 + k * 113 + 7) & 255);
                model_push(push_byte);
                k++;
                rf--;
            end
            @(negedge clk);
            t++;
        end
        push_valid = 1'b0;
    endtask

    initial begin
        int nb, bt, bb, len;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5", "idle txclk", int'(txclk), 1);
        chk("R5", "idle txd", int'(txd), 1);
        chk("R1", "reset fill", int'(fill_level), 0);
        chk("R6", "reset busy/done", int'({busy, done}), 0);
        chk("R9", "reset flags", int'({ovr_flag, und_flag}), 0);

        // divider sweep with one-shot frames (R2 R4 R6 R11)
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                div_lo = 4'(a);
                div_hi = 4'(b);
                len = ((a + b) % 2 != 0) ? 10 : 30;
                for (int p = 0; mc < len; p++) push_b(8'((a * 53 + b * 17 + p * 71 + 3) & 255));
                frame(len, (a + 1) * (b + 1), 1'b0, 0, 0, nb, bt, bb);
                chk("R6", "bit count", nb, len);
                chk("R4", "phase timing errors (R11 ratio)", bt, 0);
                chk("R2", "bit order errors", bb, 0);
                chk("R6", "done after frame", int'(done), 1);
                chk("R1", "fill after frame", int'(fill_level), mc);
            end
        end

        // drain the leftover bits, then the 32-bit boundary
        div_lo = 4'd0; div_hi = 4'd0;
        if (mc > 0) begin
            len = mc;
            frame(len, 1, 1'b0, 0, 0, nb, bt, bb);
            chk("R6", "drain count", nb, len);
        end
        chk("R1", "empty after drain", int'(fill_level), 0);
        for (int p = 0; p < 4; p++) push_b(8'(8'hA5 ^ (p * 60)));
        chk("R1", "full fill", int'(fill_level), 32);
        pulse_go(33);
        repeat (3) @(negedge clk);
        chk("R3", "len 33 ignored busy", int'(busy), 0);
        chk("R3", "len 33 fill unchanged", int'(fill_level), 32);

        // overrun, sticky flag and same-cycle clear (R8 R9)
        @(negedge clk);
        push_valid = 1'b1; push_byte = 8'h3C;
        @(negedge clk);
        push_valid = 1'b0;
        chk("R8", "overrun flag", int'(ovr_flag), 1);
        chk("R8", "fill after dropped push", int'(fill_level), 32);
        push_valid = 1'b1; clr_ovr = 1'b1;
        @(negedge clk);
        push_valid = 1'b0; clr_ovr = 1'b0;
        chk("R9", "set beats clear", int'(ovr_flag), 1);
        clr_ovr = 1'b1;
        @(negedge clk);
        clr_ovr = 1'b0;
        chk("R9", "clear pulse", int'(ovr_flag), 0);

        frame(32, 1, 1'b0, 0, 0, nb, bt, bb);
        chk("R3", "len 32 accepted, bit count", nb, 32);
        chk("R2", "len 32 bit order", bb, 0);
        chk("R1", "empty after 32", int'(fill_level), 0);
        pulse_go(5);
        repeat (2) @(negedge clk);
        chk("R3", "short fifo go ignored", int'(busy), 0);
        chk("R6", "done holds until accepted go", int'(done), 1);

        // streaming with refills until it starves (R7)
        div_lo = 4'd3; div_hi = 4'd0;
        for (int p = 0; p < 4; p++) push_b(8'(p * 37 + 11));
        frame(0, 4, 1'b0, 3, 5, nb, bt, bb);
        chk("R7", "streamed bit count", nb, 56);
        chk("R7", "stream timing", bt, 0);
        chk("R2", "stream order across refills", bb, 0);
        chk("R7", "underrun flag", int'(und_flag), 1);
        chk("R7", "no done on stream", int'(done), 0);
        clr_und = 1'b1;
        @(negedge clk);
        clr_und = 1'b0;
        chk("R9", "underrun cleared", int'(und_flag), 0);
        pulse_go(0);
        @(negedge clk);
        chk("R7", "empty stream go underrun", int'(und_flag), 1);
        chk("R7", "empty stream go no start", int'(busy), 0);

        // external source tick (R10)
        clk_src_sel = 1'b1; aux_en = 1'b1;
        div_lo = 4'd1; div_hi = 4'd0;
        push_b(8'hC3); push_b(8'h5A);
        frame(16, 6, 1'b1, 0, 0, nb, bt, bb);
        chk("R10", "aux bit count", nb, 16);
        chk("R10", "aux phase timing", bt, 0);
        chk("R10", "aux bit order", bb, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule